// File: doc/BRIEF.md
# Nonvolatile Shadow Transfer Sequencer

This block controls the two bulk transfers between a volatile RAM array and the nonvolatile shadow copy behind each of its cells. A save copies RAM into the shadow copy. It has two phases: the old shadow contents are erased, then the current RAM contents are programmed in. A restore loads the shadow copy back into RAM. It also has two phases: RAM is cleared, then the shadow data is copied in. A restore never changes the shadow copy.

A command detector sends single-cycle save and restore requests. A supply comparator reports whether the supply is above the switch threshold. When that comparator output goes high, the block starts a restore by itself. This restore uses its own, shorter, phase lengths. While any transfer runs, the block raises a busy flag. The flag locks out host accesses and holds the data pins in high impedance. The block also drives one control line per array phase.

Each phase length is a cycle-count parameter. Defaults assume a 100 MHz clock: save 10 ms, software restore 20 ms, power-up restore 650 us. A simulation can override them with small values. A low supply blocks a save from starting and cancels a save that is running. A cancelled save sets a sticky flag. A low supply never affects a restore.

Top module: `shadow_xfer_seq`

## Requirements
- R1: An accepted save drives `ph_erase` for exactly `SAVE_ERASE_CYC` cycles, then `ph_prog` for exactly `SAVE_PROG_CYC` cycles. No two phase outputs are ever high together.
- R2: An accepted software restore drives `ph_clear` for exactly `LOAD_CLEAR_CYC` cycles, then `ph_copy` for exactly `LOAD_COPY_CYC` cycles.
- R3: `busy` and `dq_hiz` rise in the cycle after the clock edge that accepts a request. They fall in the cycle after the last cycle of the final phase. `dq_hiz` always equals `busy`.
- R4: A save request, a restore request or a supply rising edge that arrives while `busy` is high is dropped. It does not start a transfer later.
- R5: A save request made while `pwr_ok` is 0 is ignored, and the block stays idle.
- R6: If `pwr_ok` is 0 at a clock edge during the erase or program phase, the save ends at that edge. `busy` goes to 0 and `store_aborted` goes to 1. A software or power-up restore runs to completion whatever the value of `pwr_ok`, and a software restore may start while `pwr_ok` is 0.
- R7: When idle, a 0-to-1 change of `pwr_ok` starts a power-up restore. This includes `pwr_ok` being 1 at the first edge after reset. The restore runs `BOOT_CLEAR_CYC` clear cycles, then `BOOT_COPY_CYC` copy cycles. This start wins over any request in the same cycle.
- R8: `store_aborted` stays at 1 until a save finishes its program phase, or until reset. A restore does not clear it.
- R9: When a save request and a restore request arrive in the same idle cycle, the restore is performed and the save is dropped.
- R10: While `rst_n` is 0 at a clock edge, all outputs go to 0 and any transfer stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| store_req | input | 1 | Save request pulse from the command detector |
| recall_req | input | 1 | Restore request pulse from the command detector |
| pwr_ok | input | 1 | Supply above the switch threshold |
| busy | output | 1 | Transfer in progress; host accesses are locked out |
| dq_hiz | output | 1 | Hold the data pins in high impedance |
| ph_erase | output | 1 | Shadow erase phase active |
| ph_prog | output | 1 | Shadow program phase active |
| ph_clear | output | 1 | RAM clear phase active |
| ph_copy | output | 1 | Shadow-to-RAM copy phase active |
| store_aborted | output | 1 | Sticky flag: a save was cancelled by low supply |

## Verification
The bench checks exact phase lengths, so a timer that is off by one shows up as one extra or one missing cycle of erase or copy. It checks that a restore request sent during a save has no effect, then or later; a design that queued requests would start a restore once the save ended. It drops the supply in both save phases and once during a power-up restore. A wrong design would either let the save finish or cut the restore short. Further cases cover a supply rise during a transfer, both requests in the same cycle, a restore started while the supply is low, and supply already high when reset is released; a design that got these wrong would skip or misplace the power-up restore, or leave the sticky flag in the wrong state.

// File: rtl/nvs_pkg.sv
// Package: shared state type and helper for the shadow transfer sequencer.
// Assumes: nothing outside this package.
package nvs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE,
        S_PROG,
        S_CLEAR,
        S_COPY
    } nvs_state_t;

    // Larger of two counts, used to size the phase counter.
    function automatic int nvs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvs_pwr_edge.sv
// Supply edge detector: outputs a one-cycle pulse when pwr_ok goes from 0 to 1.
// Assumes: pwr_ok is already synchronous to clk. The stored previous value
// resets to 0, so a supply already high at reset release counts as a rise.
module nvs_pwr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic pwr_rise
);
    logic pwr_q;

    // Keep the previous supply level.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= pwr_ok;
    end

    // A rise is a high level that was low one cycle earlier.
    always_comb pwr_rise = pwr_ok && !pwr_q;

    // R7: the rise pulse never lasts two cycles in a row.
    p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_rise |=> !pwr_rise);
endmodule

// File: rtl/nvs_timer.sv
// Phase timer: counts the cycles spent in the current phase and flags the
// last one.
// Assumes: lim >= 1 and stays stable between restarts. restart is held high
// in idle and in each cycle where the phase changes.
module nvs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] lim,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Clear on restart, count up otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else                   cnt_q <= cnt_q + CW'(1);
    end

    // The phase is in its last cycle when the count reaches lim-1.
    always_comb done = (cnt_q == lim - CW'(1));

    // R1: the count never passes the limit of the phase it is timing.
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim);
endmodule

// File: rtl/nvs_fsm.sv
// Transfer state machine: accepts requests, steps through the two phases of
// a save or a restore, applies the low-supply rules and keeps the sticky
// abort flag.
// Assumes: each request is a one-cycle pulse and the timer restarts on
// every phase change.
module nvs_fsm
    import nvs_pkg::*;
#(
    parameter int CW             = 8,
    parameter int SAVE_ERASE_CYC = 3,
    parameter int SAVE_PROG_CYC  = 4,
    parameter int LOAD_CLEAR_CYC = 2,
    parameter int LOAD_COPY_CYC  = 5,
    parameter int BOOT_CLEAR_CYC = 1,
    parameter int BOOT_COPY_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_req,
    input  logic          recall_req,
    input  logic          pwr_ok,
    input  logic          pwr_rise,
    input  logic          done,
    output logic          restart,
    output logic [CW-1:0] lim,
    output nvs_state_t    state,
    output logic          abort_flag
);
    nvs_state_t state_q, state_d;
    logic       boot_q, boot_d;
    logic       abort_q, abort_d;

    // Choose the next phase, the restore kind and the abort flag.
    always_comb begin
        state_d = state_q;
        boot_d  = boot_q;
        abort_d = abort_q;
        unique case (state_q)
            S_IDLE: begin
                if (pwr_rise) begin
                    state_d = S_CLEAR;
                    boot_d  = 1'b1;
                end else if (recall_req) begin
                    state_d = S_CLEAR;
                    boot_d  = 1'b0;
                end else if (store_req && pwr_ok) begin
                    state_d = S_ERASE;
                end
            end
            S_ERASE: begin
                if (!pwr_ok) begin
                    state_d = S_IDLE;
                    abort_d = 1'b1;
                end else if (done) begin
                    state_d = S_PROG;
                end
            end
            S_PROG: begin
                if (!pwr_ok) begin
                    state_d = S_IDLE;
                    abort_d = 1'b1;
                end else if (done) begin
                    state_d = S_IDLE;
                    abort_d = 1'b0;
                end
            end
            S_CLEAR: if (done) state_d = S_COPY;
            S_COPY:  if (done) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Register the state, the restore kind and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            boot_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            boot_q  <= boot_d;
            abort_q <= abort_d;
        end
    end

    // Give the timer the limit of the phase now running.
    always_comb begin
        unique case (state_q)
            S_ERASE: lim = CW'(SAVE_ERASE_CYC);
            S_PROG:  lim = CW'(SAVE_PROG_CYC);
            S_CLEAR: lim = boot_q ? CW'(BOOT_CLEAR_CYC) : CW'(LOAD_CLEAR_CYC);
            S_COPY:  lim = boot_q ? CW'(BOOT_COPY_CYC)  : CW'(LOAD_COPY_CYC);
            default: lim = CW'(1);
        endcase
    end

    // Restart the timer while idle and whenever the phase changes.
    always_comb restart = (state_q == S_IDLE) || (state_d != state_q);

    assign state      = state_q;
    assign abort_flag = abort_q;

    // R5: with the supply low, an idle sequencer never enters the erase phase.
    p_no_save_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !pwr_ok) |=> state_q != S_ERASE);
    // R6: low supply in a save phase ends the save and sets the flag.
    p_save_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_ERASE || state_q == S_PROG) && !pwr_ok)
        |=> (state_q == S_IDLE && abort_q));
    // R6: a restore phase that has not timed out continues at low supply.
    p_load_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COPY && !done) |=> state_q == S_COPY);
    // R8: the flag stays set unless a program phase finishes.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_q && !(state_q == S_PROG && done && pwr_ok)) |=> abort_q);
    // R4: a running erase phase holds until it times out, whatever the requests.
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ERASE && pwr_ok && !done) |=> state_q == S_ERASE);
endmodule

// File: rtl/shadow_xfer_seq.sv
// Top level of the shadow transfer sequencer: wires the supply edge
// detector, the phase timer and the state machine together and decodes the
// phase outputs.
// Assumes: all inputs are synchronous to clk and every phase count is >= 1.
module shadow_xfer_seq
    import nvs_pkg::*;
#(
    parameter int SAVE_ERASE_CYC = 400000,
    parameter int SAVE_PROG_CYC  = 600000,
    parameter int LOAD_CLEAR_CYC = 100000,
    parameter int LOAD_COPY_CYC  = 1900000,
    parameter int BOOT_CLEAR_CYC = 5000,
    parameter int BOOT_COPY_CYC  = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_req,
    input  logic recall_req,
    input  logic pwr_ok,
    output logic busy,
    output logic dq_hiz,
    output logic ph_erase,
    output logic ph_prog,
    output logic ph_clear,
    output logic ph_copy,
    output logic store_aborted
);
    localparam int MAX_SAVE = nvs_max(SAVE_ERASE_CYC, SAVE_PROG_CYC);
    localparam int MAX_LOAD = nvs_max(LOAD_CLEAR_CYC, LOAD_COPY_CYC);
    localparam int MAX_BOOT = nvs_max(BOOT_CLEAR_CYC, BOOT_COPY_CYC);
    localparam int MAX_CYC  = nvs_max(MAX_SAVE, nvs_max(MAX_LOAD, MAX_BOOT));
    localparam int CW       = $clog2(MAX_CYC + 1);

    logic          pwr_rise;
    logic          done;
    logic          restart;
    logic [CW-1:0] lim;
    nvs_state_t    state;

    nvs_pwr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .pwr_rise (pwr_rise)
    );

    nvs_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .lim     (lim),
        .done    (done)
    );

    nvs_fsm #(
        .CW             (CW),
        .SAVE_ERASE_CYC (SAVE_ERASE_CYC),
        .SAVE_PROG_CYC  (SAVE_PROG_CYC),
        .LOAD_CLEAR_CYC (LOAD_CLEAR_CYC),
        .LOAD_COPY_CYC  (LOAD_COPY_CYC),
        .BOOT_CLEAR_CYC (BOOT_CLEAR_CYC),
        .BOOT_COPY_CYC  (BOOT_COPY_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_req  (store_req),
        .recall_req (recall_req),
        .pwr_ok     (pwr_ok),
        .pwr_rise   (pwr_rise),
        .done       (done),
        .restart    (restart),
        .lim        (lim),
        .state      (state),
        .abort_flag (store_aborted)
    );

    // Decode the registered state into phase and lockout outputs.
    always_comb begin
        ph_erase = (state == S_ERASE);
        ph_prog  = (state == S_PROG);
        ph_clear = (state == S_CLEAR);
        ph_copy  = (state == S_COPY);
        busy     = (state != S_IDLE);
        dq_hiz   = busy;
    end

    // R2: the copy phase only ever starts straight after the clear phase.
    p_copy_after_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_copy) |-> $past(ph_clear));
    // R1: the program phase only ever starts straight after the erase phase.
    p_prog_after_erase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_prog) |-> $past(ph_erase));
    // R3: the erase phase ends either in programming or, on abort, in idle.
    p_erase_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph_erase) |-> (ph_prog || !busy));
endmodule

// File: tb/shadow_xfer_seq_bench.sv
module shadow_xfer_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 62;

    // Expected outputs {busy, erase, prog, clear, copy, aborted}.
    localparam logic [5:0] X_ID  = 6'b000000;
    localparam logic [5:0] X_IDA = 6'b000001;
    localparam logic [5:0] X_ER  = 6'b110000;
    localparam logic [5:0] X_ERA = 6'b110001;
    localparam logic [5:0] X_PG  = 6'b101000;
    localparam logic [5:0] X_PGA = 6'b101001;
    localparam logic [5:0] X_CL  = 6'b100100;
    localparam logic [5:0] X_CLA = 6'b100101;
    localparam logic [5:0] X_CP  = 6'b100010;
    localparam logic [5:0] X_CPA = 6'b100011;

    // Row: {tag, store_req, recall_req, pwr_ok, expected after the next edge}.
    localparam logic [12:0] VEC [NV] = '{
        {4'd10, 3'b000, X_ID },
        {4'd5,  3'b100, X_ID },
        {4'd7,  3'b001, X_CL },
        {4'd7,  3'b001, X_CP },
        {4'd7,  3'b001, X_CP },
        {4'd3,  3'b001, X_ID },
        {4'd1,  3'b101, X_ER },
        {4'd4,  3'b011, X_ER },
        {4'd1,  3'b001, X_ER },
        {4'd1,  3'b001, X_PG },
        {4'd1,  3'b001, X_PG },
        {4'd1,  3'b001, X_PG },
        {4'd1,  3'b001, X_PG },
        {4'd3,  3'b001, X_ID },
        {4'd1,  3'b101, X_ER },
        {4'd1,  3'b001, X_ER },
        {4'd6,  3'b000, X_IDA},
        {4'd7,  3'b001, X_CLA},
        {4'd6,  3'b000, X_CPA},
        {4'd4,  3'b001, X_CPA},
        {4'd3,  3'b001, X_IDA},
        {4'd2,  3'b011, X_CLA},
        {4'd2,  3'b001, X_CLA},
        {4'd2,  3'b001, X_CPA},
        {4'd2,  3'b001, X_CPA},
        {4'd2,  3'b001, X_CPA},
        {4'd2,  3'b001, X_CPA},
        {4'd2,  3'b001, X_CPA},
        {4'd8,  3'b001, X_IDA},
        {4'd9,  3'b111, X_CLA},
        {4'd9,  3'b001, X_CLA},
        {4'd9,  3'b001, X_CPA},
        {4'd9,  3'b001, X_CPA},
        {4'd9,  3'b001, X_CPA},
        {4'd9,  3'b001, X_CPA},
        {4'd9,  3'b001, X_CPA},
        {4'd9,  3'b001, X_IDA},
        {4'd8,  3'b101, X_ERA},
        {4'd8,  3'b001, X_ERA},
        {4'd8,  3'b001, X_ERA},
        {4'd8,  3'b001, X_PGA},
        {4'd8,  3'b001, X_PGA},
        {4'd8,  3'b001, X_PGA},
        {4'd8,  3'b001, X_PGA},
        {4'd8,  3'b001, X_ID },
        {4'd6,  3'b101, X_ER },
        {4'd6,  3'b001, X_ER },
        {4'd6,  3'b001, X_ER },
        {4'd6,  3'b001, X_PG },
        {4'd6,  3'b000, X_IDA},
        {4'd6,  3'b010, X_CLA},
        {4'd6,  3'b000, X_CLA},
        {4'd6,  3'b000, X_CPA},
        {4'd6,  3'b000, X_CPA},
        {4'd6,  3'b000, X_CPA},
        {4'd6,  3'b000, X_CPA},
        {4'd6,  3'b000, X_CPA},
        {4'd6,  3'b000, X_IDA},
        {4'd7,  3'b001, X_CLA},
        {4'd7,  3'b001, X_CPA},
        {4'd7,  3'b001, X_CPA},
        {4'd7,  3'b001, X_IDA}
    };

    logic clk = 1'b0;
    logic rst_n, store_req, recall_req, pwr_ok;
    logic busy, dq_hiz, ph_erase, ph_prog, ph_clear, ph_copy, store_aborted;
    int   n_chk = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shadow_xfer_seq #(
        .SAVE_ERASE_CYC (3),
        .SAVE_PROG_CYC  (4),
        .LOAD_CLEAR_CYC (2),
        .LOAD_COPY_CYC  (5),
        .BOOT_CLEAR_CYC (1),
        .BOOT_COPY_CYC  (2)
    ) u_shadow_xfer_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .store_req     (store_req),
        .recall_req    (recall_req),
        .pwr_ok        (pwr_ok),
        .busy          (busy),
        .dq_hiz        (dq_hiz),
        .ph_erase      (ph_erase),
        .ph_prog       (ph_prog),
        .ph_clear      (ph_clear),
        .ph_copy       (ph_copy),
        .store_aborted (store_aborted)
    );

    function automatic string rtag(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {busy, ph_erase, ph_prog, ph_clear, ph_copy, store_aborted};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s outputs actual=%b expected=%b", req, act, exp);
        end
        n_chk++;
        if (dq_hiz !== exp[5]) begin
            n_bad++;
            $display("FAIL R3 dq_hiz actual=%b expected=%b", dq_hiz, exp[5]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; store_req = 1'b0; recall_req = 1'b0; pwr_ok = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", X_ID);            // R10 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {store_req, recall_req, pwr_ok} = VEC[i][8:6];
            @(posedge clk);
            @(negedge clk);
            check(rtag(VEC[i][12:9]), VEC[i][5:0]);
        end

        // R10 and R8: reset during a save clears everything, including the flag.
        store_req = 1'b1; recall_req = 1'b0; pwr_ok = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", X_ERA);
        store_req = 1'b0; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10", X_ID);
        check("R8", X_ID);

        // R7: supply already high at reset release starts a power-up restore.
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7", X_CL);
        @(posedge clk); @(negedge clk);
        check("R7", X_CP);
        @(posedge clk); @(negedge clk);
        check("R7", X_CP);
        @(posedge clk); @(negedge clk);
        check("R7", X_ID);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule